// File: doc/BRIEF.md
# Serial Register Port with Streaming Address Increment

This block is a four-wire serial slave that lets an external host read and write a bank of 8-bit registers held inside the block. The host pulls an active-low frame select down, toggles a serial clock and presents bits on its data line; the block answers on its own data-out line. Each frame starts with a header byte of seven address bits, MSB first, followed by one direction bit. After the header come one or more data bytes. A frame that stays open after its first data byte keeps going: each further byte goes to, or comes from, the next register address.

All four serial pins are brought into the block's own clock domain through a short synchronizer chain. Serial clock edges are detected there, so the serial clock must run several times slower than `clk`. The rest of the chip sees the bank through a combinational parallel read port. It also sees a one-cycle write-event strobe that carries the address and the stored value of every committed byte. The serial host cannot be stalled, so the write-event output has no ready input and no back-pressure: consumers must take each strobe in the cycle it appears.

Top module: `spi_regport`

## Requirements
- R1: A frame opens when `spi_cs_n` falls. While `spi_cs_n` is high, the bit position is held at zero. A data byte cut short by `spi_cs_n` rising is dropped: no register changes and no write event is raised.
- R2: The first eight bits of a frame, sampled on rising serial clock edges, form the header. Header bits 7..1 are the register address, MSB first. Header bit 0 is the direction: 0 = write, 1 = read. Seen as a 16-bit word, this is address [15:9], direction [8], data [7:0].
- R3: In a write frame, the next eight bits, MSB first, are stored at the header address. The store happens on the rising edge of the eighth data bit.
- R4: In a read frame, the addressed register is shifted out on `spi_miso` MSB first. The MSB is present before the first data rising edge, and each later bit appears after a falling serial clock edge.
- R5: In a read frame, the bits on `spi_mosi` after the direction bit change no register.
- R6: A write frame kept open past its first data byte stores each further byte at the next higher address.
- R7: A read frame kept open past its first data byte shifts out the next higher register for each further byte.
- R8: The running address wraps from 127 to 0 in both directions of transfer.
- R9: At addresses 112 and above, bits 7..4 are reserved and are stored as 0 whatever is written. All bits are writable below address 112.
- R10: `spi_miso` is driven low while `spi_cs_n` is high and throughout write frames.
- R11: `reg_rd_data` always shows the register selected by `reg_rd_addr`. Each committed byte pulses `wr_valid` for one cycle, with `wr_addr` and the stored, masked value on `wr_data`.
- R12: Reset clears every register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_rd_addr | input | 7 | Parallel read address |
| reg_rd_data | output | 8 | Register at `reg_rd_addr` |
| wr_valid | output | 1 | One-cycle pulse per committed serial write |
| wr_addr | output | 7 | Address of the committed write |
| wr_data | output | 8 | Value stored by the committed write |

## Verification
A pin edge reaches the frame logic three `clk` cycles later: two synchronizer flops, then the register that acts on the detected edge. A store, a write event or a new `spi_miso` bit therefore lands on the third clock after the serial clock edge that causes it. The bench holds every serial clock phase for eight `clk` cycles. It samples `spi_miso` just before each rising edge, as a host would. It reads registers through the parallel port only after the frame has closed and two further serial half-periods have passed, so every sample falls well after its result is due.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_t;

  // Writable-bit mask for a register: reserved bits above the base are forced to 0.
  function automatic logic [31:0] keep_mask(input int addr, input int base,
                                            input logic [31:0] keep);
    return (addr >= base) ? keep : 32'hFFFF_FFFF;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] synced,
  output logic [WIDTH-1:0] prev
);

  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= RST_VAL;
          else        pipe[0] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= RST_VAL;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  // One more flop so the caller can detect edges on the synchronized value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST_VAL;
    else        prev <= pipe[STAGES-1];
  end

  assign synced = pipe[STAGES-1];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_word,
  output logic              miso
);

  localparam int HDR_W   = ADDR_W + 1;
  localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CW      = $clog2(CNT_MAX);
  localparam int SH_W    = (ADDR_W > DATA_W - 1) ? ADDR_W : DATA_W - 1;
  localparam logic [CW-1:0] HDR_LAST = CW'(HDR_W - 1);
  localparam logic [CW-1:0] DAT_LAST = CW'(DATA_W - 1);

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [SH_W-1:0]   sh;
  logic [SH_W:0]     next_sh;
  logic [DATA_W-1:0] obuf;
  logic              obuf_vld;
  logic              load_pend;
  logic              shift_pend;

  assign next_sh = {sh, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_HDR;
      cnt        <= '0;
      sh         <= '0;
      ptr        <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_word    <= '0;
      obuf       <= '0;
      obuf_vld   <= 1'b0;
      load_pend  <= 1'b0;
      shift_pend <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (cs_s) begin
        phase      <= PH_HDR;
        cnt        <= '0;
        obuf_vld   <= 1'b0;
        load_pend  <= 1'b0;
        shift_pend <= 1'b0;
      end else begin
        if (sclk_rise) begin
          sh <= next_sh[SH_W-1:0];
          case (phase)
            PH_HDR: begin
              if (cnt == HDR_LAST) begin
                ptr   <= next_sh[ADDR_W:1];
                phase <= next_sh[0] ? PH_RD : PH_WR;
                cnt   <= '0;
                if (next_sh[0]) load_pend <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_WR: begin
              if (cnt == DAT_LAST) begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_word <= next_sh[DATA_W-1:0];
                ptr     <= ptr + 1'b1;
                cnt     <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            PH_RD: begin
              if (cnt == DAT_LAST) begin
                ptr       <= ptr + 1'b1;
                load_pend <= 1'b1;
                cnt       <= '0;
              end else begin
                cnt        <= cnt + 1'b1;
                shift_pend <= 1'b1;
              end
            end
            default: phase <= PH_HDR;
          endcase
        end
        if (sclk_fall) begin
          if (load_pend) begin
            obuf      <= rd_data;
            obuf_vld  <= 1'b1;
            load_pend <= 1'b0;
          end else if (shift_pend) begin
            obuf       <= {obuf[DATA_W-2:0], 1'b0};
            shift_pend <= 1'b0;
          end
        end
      end
    end
  end

  assign miso = (phase == PH_RD) && obuf_vld && !cs_s && obuf[DATA_W-1];

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RSVD_BASE = 112,
  parameter logic [DATA_W-1:0] RSVD_KEEP = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  // Pin vector order: [2] frame select, [1] serial clock, [0] data in.
  logic [2:0] pin_raw, pin_s, pin_p;
  logic cs_sync, sclk_rise, sclk_fall;

  logic [ADDR_W-1:0] ptr;
  logic [DATA_W-1:0] ptr_data;
  logic              eng_we;
  logic [ADDR_W-1:0] eng_addr;
  logic [DATA_W-1:0] eng_word;
  logic [DATA_W-1:0] wmask;

  assign pin_raw = {spi_cs_n, spi_sclk, spi_mosi};

  spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins(pin_raw), .synced(pin_s), .prev(pin_p)
  );

  assign cs_sync   = pin_s[2];
  assign sclk_rise = pin_s[1] & ~pin_p[1];
  assign sclk_fall = ~pin_s[1] & pin_p[1];

  spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_sync), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .mosi_s(pin_s[0]), .rd_data(ptr_data), .ptr(ptr),
    .wr_en(eng_we), .wr_addr(eng_addr), .wr_word(eng_word), .miso(spi_miso)
  );

  assign wmask = DATA_W'(keep_mask(int'(eng_addr), RSVD_BASE, 32'(RSVD_KEEP)));

  assign wr_valid = eng_we;
  assign wr_addr  = eng_addr;
  assign wr_data  = eng_word & wmask;

  spi_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(eng_we), .waddr(eng_addr), .wdata(wr_data),
    .raddr_a(ptr), .rdata_a(ptr_data), .raddr_b(reg_rd_addr), .rdata_b(reg_rd_data)
  );

endmodule

// File: rtl/spi_regport_checker.sv
module spi_regport_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int RSVD_BASE = 112,
  parameter logic [DATA_W-1:0] RSVD_KEEP = 8'h0F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              sclk_fall,
  input logic              miso,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);

  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
    end else if (cs_s) begin
      have_prev <= 1'b0;
    end else if (wr_valid) begin
      have_prev <= 1'b1;
      prev_addr <= wr_addr;
    end
  end

  // R6, R8: consecutive writes within one frame step the address by one, wrapping.
  assert_block_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && have_prev) |-> (wr_addr == prev_addr + 1'b1));

  // R9: reserved bits are never stored as 1.
  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (int'(wr_addr) >= RSVD_BASE)) |-> ((wr_data & ~RSVD_KEEP) == '0));

  // R11: a write event lasts a single cycle.
  assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R10: output stays low while a write is being committed.
  assert_miso_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !miso);

  // R4: inside an open frame, output bits move only after a falling serial clock edge.
  assert_miso_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(miso) && !cs_s && $past(!cs_s)) |-> $past(sclk_fall));

endmodule

bind spi_regport spi_regport_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RSVD_BASE(RSVD_BASE), .RSVD_KEEP(RSVD_KEEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_sync), .sclk_fall(sclk_fall), .miso(spi_miso),
  .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/spi_regport_test.sv
module spi_regport_test;

  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       miso;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wr_valid;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0;
  int errors = 0;
  int wr_count = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) if (wr_valid) wr_count++;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic close_frame();
    wait_clk(HP);
    cs_n = 1'b1;
    wait_clk(2 * HP);
  endtask

  // Sends n bits of din MSB first, returning what was seen on miso before each rise.
  task automatic shift_bits(input logic [7:0] din, input int n, output logic [7:0] dout);
    dout = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = din[i];
      wait_clk(HP);
      dout[i] = miso;
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic peek(input logic [6:0] a, input string req, input int exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic t_reset();
    check("R10 reset miso", miso, 0);
    peek(7'd0, "R12 reset reg0", 8'h00);
    peek(7'd5, "R12 reset reg5", 8'h00);
    peek(7'd127, "R12 reset reg127", 8'h00);
  endtask

  task automatic t_single_write();
    logic [7:0] d;
    int w0;
    w0 = wr_count;
    open_frame();
    shift_bits({7'd5, 1'b0}, 8, d);
    check("R10 miso low in header", d, 8'h00);
    shift_bits(8'hA5, 8, d);
    check("R10 miso low in write data", d, 8'h00);
    close_frame();
    peek(7'd5, "R3 write stored", 8'hA5);
    peek(7'd4, "R2 neighbour untouched", 8'h00);
    check("R11 one write event", wr_count - w0, 1);
  endtask

  task automatic t_single_read();
    logic [7:0] d;
    int w0;
    w0 = wr_count;
    open_frame();
    shift_bits({7'd5, 1'b1}, 8, d);
    shift_bits(8'hFF, 8, d);
    check("R4 read data", d, 8'hA5);
    close_frame();
    peek(7'd5, "R5 read leaves register", 8'hA5);
    check("R5 no write event on read", wr_count - w0, 0);
    check("R10 miso low after frame", miso, 0);
  endtask

  task automatic t_block_write();
    logic [7:0] d;
    open_frame();
    shift_bits({7'd10, 1'b0}, 8, d);
    shift_bits(8'h11, 8, d);
    shift_bits(8'h22, 8, d);
    shift_bits(8'h33, 8, d);
    close_frame();
    peek(7'd10, "R6 block byte0", 8'h11);
    peek(7'd11, "R6 block byte1", 8'h22);
    peek(7'd12, "R6 block byte2", 8'h33);
    peek(7'd13, "R6 block stops", 8'h00);
  endtask

  task automatic t_block_read();
    logic [7:0] d;
    open_frame();
    shift_bits({7'd10, 1'b1}, 8, d);
    shift_bits(8'h00, 8, d);
    check("R7 block read byte0", d, 8'h11);
    shift_bits(8'h00, 8, d);
    check("R7 block read byte1", d, 8'h22);
    shift_bits(8'h00, 8, d);
    check("R7 block read byte2", d, 8'h33);
    close_frame();
  endtask

  task automatic t_wrap_mask();
    logic [7:0] d;
    open_frame();
    shift_bits({7'd127, 1'b0}, 8, d);
    shift_bits(8'h5A, 8, d);
    shift_bits(8'h77, 8, d);
    close_frame();
    peek(7'd127, "R9 reserved bits cleared", 8'h0A);
    peek(7'd0, "R8 write wraps to 0", 8'h77);
    open_frame();
    shift_bits({7'd112, 1'b0}, 8, d);
    shift_bits(8'hFF, 8, d);
    close_frame();
    peek(7'd112, "R9 mask at base", 8'h0F);
    open_frame();
    shift_bits({7'd111, 1'b0}, 8, d);
    shift_bits(8'hF3, 8, d);
    close_frame();
    peek(7'd111, "R9 full width below base", 8'hF3);
    open_frame();
    shift_bits({7'd127, 1'b1}, 8, d);
    shift_bits(8'h00, 8, d);
    check("R7 read at top", d, 8'h0A);
    shift_bits(8'h00, 8, d);
    check("R8 read wraps to 0", d, 8'h77);
    close_frame();
  endtask

  task automatic t_partial();
    logic [7:0] d;
    int w0;
    w0 = wr_count;
    open_frame();
    shift_bits({7'd20, 1'b0}, 8, d);
    shift_bits(8'hC0, 4, d);
    close_frame();
    peek(7'd20, "R1 partial byte dropped", 8'h00);
    check("R1 no event for partial", wr_count - w0, 0);
    open_frame();
    shift_bits({7'd20, 1'b0}, 8, d);
    shift_bits(8'h99, 8, d);
    close_frame();
    peek(7'd20, "R1 next frame aligned", 8'h99);
  endtask

  task automatic t_event_fields();
    logic [7:0] d;
    logic [6:0] ca;
    logic [7:0] cd;
    open_frame();
    shift_bits({7'd115, 1'b0}, 8, d);
    fork
      shift_bits(8'hE6, 8, d);
      begin
        @(negedge clk iff wr_valid);
        ca = wr_addr;
        cd = wr_data;
      end
    join
    close_frame();
    check("R11 event address", ca, 115);
    check("R11 event data masked", cd, 8'h06);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_single_write();
    t_single_read();
    t_block_write();
    t_block_read();
    t_wrap_mask();
    t_partial();
    t_event_fields();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule